// File: doc/BRIEF.md
# Delay-Slot Next-PC Unit

This block keeps the program-counter state of a single-issue core that executes one instruction after every control transfer (a branch delay slot). It holds three addresses: the address of the instruction that retired last (`prev_pc`), the address now being fetched (`fetch_pc`), and the address queued behind it (`next_pc`). Each time an instruction retires, the three registers shift down by one place. A new queued address enters from the target logic.

The retiring instruction's transfer kind, its compare operands, branch offset, jump index and register value decide the new queued address. A branch target is formed from the delay-slot address, which is the current `next_pc`. A direct jump keeps the upper region bits of the sequential successor. A register jump takes the full register value. The linking forms also present a return address, `next_pc + 4`, and a destination register number for the register file to write.

An exception strobe in the retire cycle cancels the whole update, including the link write. The decode and fetch stages sit outside this block.

There is one operating state, RUN. Only one event leaves RUN: the synchronous reset, which reloads the registers and returns to RUN. Inside RUN there are three transitions per cycle. ADVANCE happens on a retire without an exception. CANCEL happens on a retire with an exception. HOLD happens when there is no retire.

Top module: `dspc_npc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `fetch_pc` becomes RESET_VEC (default 0x0040_0000), `next_pc` becomes RESET_VEC+4 and `prev_pc` becomes 0.
- R2: On an edge with `retire`=1 and `exc`=0, `prev_pc` takes the old `fetch_pc` and `fetch_pc` takes the old `next_pc`. A transfer therefore reaches `fetch_pc` one retire after the instruction that requested it.
- R3: For kind 0 (sequential), and for the unused codes 13 to 15, the new `next_pc` is the old `next_pc` + 4.
- R4: When a conditional branch is taken, the new `next_pc` is the old `next_pc` plus the sign-extended 16-bit `offset` shifted left by 2. When it is not taken, the new `next_pc` is the old `next_pc` + 4.
- R5: Kind 1 is taken when `opnd_a` == `opnd_b`. Kind 2 is taken when they differ.
- R6: These kinds test `opnd_a` as a signed value and ignore `opnd_b`. Kinds 3 and 7 are taken when it is >= 0. Kinds 4 and 8 are taken when it is < 0. Kind 5 is taken when it is > 0. Kind 6 is taken when it is <= 0.
- R7: For kinds 9 and 10 (jump), the new `next_pc` is bits [31:28] of (old `next_pc` + 4) joined with `jidx` (26 bits) and two zero bits.
- R8: For kinds 11 and 12 (register jump), the new `next_pc` is `jreg_val` unchanged, with no alignment applied.
- R9: For kinds 7, 8 and 10, `link_we` is high in the retire cycle, `link_addr` is 31 and `link_data` is `next_pc` + 4. This happens whether or not the branch is taken.
- R10: For kind 12, `link_we` is high and `link_addr` equals `rd_sel`. `link_data` is `next_pc` + 4.
- R11: With `exc`=1, a retire changes none of the three registers, and `link_we` stays low.
- R12: With `retire`=0, the three registers hold their values and `link_we` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| retire | input | 1 | An instruction retires this cycle |
| exc | input | 1 | Exception in the retiring instruction; cancels the update |
| xfer_kind | input | 4 | Transfer kind of the retiring instruction (codes 0 to 12) |
| opnd_a | input | 32 | First compare operand |
| opnd_b | input | 32 | Second compare operand (equality kinds only) |
| offset | input | 16 | Signed word offset of a branch |
| jidx | input | 26 | Word index of a direct jump |
| jreg_val | input | 32 | Target of a register jump |
| rd_sel | input | 5 | Link destination for the register-jump-and-link kind |
| fetch_pc | output | 32 | Current fetch address |
| next_pc | output | 32 | Queued (delay-slot successor) address |
| prev_pc | output | 32 | Address of the last retired instruction |
| link_we | output | 1 | Link write enable |
| link_addr | output | 5 | Link destination register |
| link_data | output | 32 | Return address |

## Verification
A wrong queued address stays hidden while it sits in `next_pc`. It shows on `fetch_pc` one retire later and on `prev_pc` two retires later. For that reason the bench compares all three registers with its model after every clock, so that a bad target is caught in the cycle it is written rather than when it is fetched. A wrong taken/not-taken decision, or a wrong jump region, shows in `next_pc` on the very next edge. A link fault shows combinationally on the link outputs in the retire cycle itself. A cancelled or held retire that still moves the registers shows as a mismatch at the following edge.

// File: rtl/dspc_pkg.sv
package dspc_pkg;

    typedef enum logic [3:0] {
        XK_SEQ    = 4'd0,
        XK_EQ     = 4'd1,
        XK_NE     = 4'd2,
        XK_GEZ    = 4'd3,
        XK_LTZ    = 4'd4,
        XK_GTZ    = 4'd5,
        XK_LEZ    = 4'd6,
        XK_GEZ_LK = 4'd7,
        XK_LTZ_LK = 4'd8,
        XK_JMP    = 4'd9,
        XK_JMP_LK = 4'd10,
        XK_JREG   = 4'd11,
        XK_JREG_LK= 4'd12
    } xfer_e;

    typedef enum logic [0:0] {
        ST_RUN = 1'b0
    } pcu_state_e;

endpackage

// File: rtl/dspc_cond.sv
module dspc_cond
    import dspc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  xfer_e             kind,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    output logic              taken
);
    logic neg, zero;

    always_comb begin
        neg  = a[XLEN-1];
        zero = (a == '0);
        taken = 1'b0;
        unique case (kind)
            XK_EQ:                taken = (a == b);
            XK_NE:                taken = (a != b);
            XK_GEZ, XK_GEZ_LK:    taken = !neg;
            XK_LTZ, XK_LTZ_LK:    taken = neg;
            XK_GTZ:               taken = !neg && !zero;
            XK_LEZ:               taken = neg || zero;
            default:              taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/dspc_target.sv
module dspc_target
    import dspc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int IDX_W = 26
) (
    input  xfer_e              kind,
    input  logic               taken,
    input  logic [XLEN-1:0]    npc,
    input  logic [OFF_W-1:0]   off,
    input  logic [IDX_W-1:0]   jidx,
    input  logic [XLEN-1:0]    jreg,
    output logic [XLEN-1:0]    after,
    output logic [XLEN-1:0]    ret_addr,
    output logic               is_link,
    output logic               link_to_rd
);
    localparam int REGION_W = XLEN - IDX_W - 2;
    localparam int SEXT_W   = XLEN - OFF_W - 2;

    logic [XLEN-1:0] seq_addr, br_addr, jmp_addr;

    always_comb begin
        seq_addr = npc + XLEN'(4);
        br_addr  = npc + {{SEXT_W{off[OFF_W-1]}}, off, 2'b00};
        jmp_addr = {seq_addr[XLEN-1 -: REGION_W], jidx, 2'b00};
        ret_addr = seq_addr;
        after      = seq_addr;
        is_link    = 1'b0;
        link_to_rd = 1'b0;
        unique case (kind)
            XK_EQ, XK_NE, XK_GEZ, XK_LTZ, XK_GTZ, XK_LEZ:
                after = taken ? br_addr : seq_addr;
            XK_GEZ_LK, XK_LTZ_LK: begin
                after   = taken ? br_addr : seq_addr;
                is_link = 1'b1;
            end
            XK_JMP:    after = jmp_addr;
            XK_JMP_LK: begin
                after   = jmp_addr;
                is_link = 1'b1;
            end
            XK_JREG:   after = jreg;
            XK_JREG_LK: begin
                after      = jreg;
                is_link    = 1'b1;
                link_to_rd = 1'b1;
            end
            default:   after = seq_addr;
        endcase
    end
endmodule

// File: rtl/dspc_npc_unit.sv
module dspc_npc_unit
    import dspc_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              OFF_W     = 16,
    parameter int              IDX_W     = 26,
    parameter int              RA_W      = 5,
    parameter int              LINK_REG  = 31,
    parameter logic [31:0]     RESET_VEC = 32'h0040_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               retire,
    input  logic               exc,
    input  logic [3:0]         xfer_kind,
    input  logic [XLEN-1:0]    opnd_a,
    input  logic [XLEN-1:0]    opnd_b,
    input  logic [OFF_W-1:0]   offset,
    input  logic [IDX_W-1:0]   jidx,
    input  logic [XLEN-1:0]    jreg_val,
    input  logic [RA_W-1:0]    rd_sel,
    output logic [XLEN-1:0]    fetch_pc,
    output logic [XLEN-1:0]    next_pc,
    output logic [XLEN-1:0]    prev_pc,
    output logic               link_we,
    output logic [RA_W-1:0]    link_addr,
    output logic [XLEN-1:0]    link_data
);
    localparam logic [XLEN-1:0] VEC      = XLEN'(RESET_VEC);
    localparam logic [RA_W-1:0] LINK_IDX = RA_W'(LINK_REG);

    xfer_e           kind;
    pcu_state_e      state, state_nx;
    logic            taken, is_link, link_to_rd, advance;
    logic [XLEN-1:0] after, ret_addr;

    assign kind = xfer_e'(xfer_kind);

    dspc_cond #(.XLEN(XLEN)) u_cond (
        .kind  (kind),
        .a     (opnd_a),
        .b     (opnd_b),
        .taken (taken)
    );

    dspc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tgt (
        .kind       (kind),
        .taken      (taken),
        .npc        (next_pc),
        .off        (offset),
        .jidx       (jidx),
        .jreg       (jreg_val),
        .after      (after),
        .ret_addr   (ret_addr),
        .is_link    (is_link),
        .link_to_rd (link_to_rd)
    );

    // Transition selection: ADVANCE, CANCEL or HOLD, all within RUN.
    always_comb begin
        state_nx = state;
        advance  = 1'b0;
        unique case (state)
            ST_RUN: advance = retire && !exc;
            default: advance = 1'b0;
        endcase
    end

    // State and PC registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_RUN;
            prev_pc  <= '0;
            fetch_pc <= VEC;
            next_pc  <= VEC + XLEN'(4);
        end else begin
            state <= state_nx;
            if (advance) begin
                prev_pc  <= fetch_pc;
                fetch_pc <= next_pc;
                next_pc  <= after;
            end
        end
    end

    // Link outputs.
    always_comb begin
        link_we   = advance && is_link;
        link_addr = link_to_rd ? rd_sel : LINK_IDX;
        link_data = ret_addr;
    end

    // R2: the shift chain moves by one slot on an advancing retire.
    assert_shift_chain_R2: assert property (@(posedge clk) disable iff (rst)
        (retire && !exc) |=> (fetch_pc == $past(next_pc)) && (prev_pc == $past(fetch_pc)));

    // R11 / R12: a cancelled or absent retire leaves the registers untouched.
    assert_hold_on_cancel_R11: assert property (@(posedge clk) disable iff (rst)
        (retire && exc) |=> $stable(fetch_pc) && $stable(next_pc) && $stable(prev_pc));
    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (rst)
        !retire |=> $stable(fetch_pc) && $stable(next_pc) && $stable(prev_pc));

    // R3: a sequential retire queues the successor of the new fetch address.
    assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
        (retire && !exc && xfer_kind == 4'd0) |=> next_pc == fetch_pc + XLEN'(4));

    // R9: the return address is one word past the address fetched after the retire.
    assert_link_ret_R9: assert property (@(posedge clk) disable iff (rst)
        link_we |=> $past(link_data) == fetch_pc + XLEN'(4));

    // R11: no link write while an exception is flagged.
    assert_no_link_on_exc_R11: assert property (@(posedge clk) disable iff (rst)
        exc |-> !link_we);
endmodule

// File: tb/tb_dspc_npc_unit.sv
module tb_dspc_npc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        retire = 1'b0, exc = 1'b0;
    logic [3:0]  xfer_kind = 4'd0;
    logic [31:0] opnd_a = '0, opnd_b = '0, jreg_val = '0;
    logic [15:0] offset = '0;
    logic [25:0] jidx = '0;
    logic [4:0]  rd_sel = '0;
    logic [31:0] fetch_pc, next_pc, prev_pc, link_data;
    logic        link_we;
    logic [4:0]  link_addr;

    localparam logic [31:0] VEC = 32'h0040_0000;

    int errors = 0;
    int checks = 0;
    logic [31:0] m_prev, m_pc, m_npc;

    always #5 clk = ~clk;

    dspc_npc_unit dut (
        .clk(clk), .rst(rst), .retire(retire), .exc(exc), .xfer_kind(xfer_kind),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .offset(offset), .jidx(jidx),
        .jreg_val(jreg_val), .rd_sel(rd_sel), .fetch_pc(fetch_pc), .next_pc(next_pc),
        .prev_pc(prev_pc), .link_we(link_we), .link_addr(link_addr), .link_data(link_data)
    );

    function automatic string tag_of(input logic [3:0] k, input logic r, input logic e);
        if (!r) return "R12";
        if (e)  return "R11";
        case (k)
            4'd1, 4'd2:            return "R5";
            4'd3, 4'd4, 4'd5, 4'd6: return "R6";
            4'd7, 4'd8:            return "R4";
            4'd9, 4'd10:           return "R7";
            4'd11, 4'd12:          return "R8";
            default:               return "R3";
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        chk(tag, "fetch_pc", fetch_pc, m_pc);
        chk(tag, "next_pc",  next_pc,  m_npc);
        chk("R2", "prev_pc", prev_pc,  m_prev);
    endtask

    // Drive one cycle at the falling edge, check link outputs, then the new state.
    task automatic step(input logic [3:0] k, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] off, input logic [25:0] ji, input logic [31:0] jr,
                        input logic [4:0] rd, input logic r, input logic e);
        bit tk, lk;
        logic [31:0] seqa, aft;
        string tg;
        xfer_kind = k; opnd_a = a; opnd_b = b; offset = off; jidx = ji;
        jreg_val = jr; rd_sel = rd; retire = r; exc = e;
        #1;
        seqa = m_npc + 32'd4;
        case (k)
            4'd1: tk = (a == b);
            4'd2: tk = (a != b);
            4'd3, 4'd7: tk = ($signed(a) >= 0);
            4'd4, 4'd8: tk = ($signed(a) < 0);
            4'd5: tk = ($signed(a) > 0);
            4'd6: tk = ($signed(a) <= 0);
            default: tk = 0;
        endcase
        if (k >= 4'd1 && k <= 4'd8) aft = tk ? m_npc + {{14{off[15]}}, off, 2'b00} : seqa;
        else if (k == 4'd9 || k == 4'd10) aft = {seqa[31:28], ji, 2'b00};
        else if (k == 4'd11 || k == 4'd12) aft = jr;
        else aft = seqa;
        lk = r && !e && (k == 4'd7 || k == 4'd8 || k == 4'd10 || k == 4'd12);
        tg = (k == 4'd12) ? "R10" : (r && e) ? "R11" : (!r) ? "R12" : "R9";
        chk(tg, "link_we", {31'd0, link_we}, {31'd0, lk});
        if (lk) begin
            chk(tg, "link_data", link_data, seqa);
            chk(tg, "link_addr", {27'd0, link_addr}, {27'd0, (k == 4'd12) ? rd : 5'd31});
        end
        if (r && !e) begin
            m_prev = m_pc; m_pc = m_npc; m_npc = aft;
        end
        @(negedge clk);
        check_state(tag_of(k, r, e));
    endtask

    task automatic do_reset();
        rst = 1'b1; retire = 1'b0; exc = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        m_prev = '0; m_pc = VEC; m_npc = VEC + 32'd4;
        check_state("R1");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R3 sequential steps and unused code
        step(4'd0, 0, 0, 0, 0, 0, 0, 1, 0);
        step(4'd14, 0, 0, 0, 0, 0, 0, 1, 0);
        // R5 equal taken, backwards offset (R4)
        step(4'd1, 32'h55, 32'h55, 16'hFFFC, 0, 0, 0, 1, 0);
        step(4'd2, 32'h55, 32'h55, 16'h0010, 0, 0, 0, 1, 0);
        step(4'd2, 32'h1, 32'h2, 16'h0008, 0, 0, 0, 1, 0);
        // R6 zero and sign boundaries
        step(4'd5, 32'h0, 0, 16'h0020, 0, 0, 0, 1, 0);
        step(4'd6, 32'h0, 0, 16'h0004, 0, 0, 0, 1, 0);
        step(4'd3, 32'h8000_0000, 0, 16'h0004, 0, 0, 0, 1, 0);
        step(4'd4, 32'h8000_0000, 0, 16'h0003, 0, 0, 0, 1, 0);
        // R7 jump keeps region
        step(4'd9, 0, 0, 0, 26'h3FF_FFFF, 0, 0, 1, 0);
        // R8 register jump, unaligned
        step(4'd11, 0, 0, 0, 0, 32'h9000_0123, 0, 1, 0);
        // R9 link on a not-taken branch
        step(4'd8, 32'h7, 0, 16'h0040, 0, 0, 0, 1, 0);
        step(4'd10, 0, 0, 0, 26'h000_0100, 0, 0, 1, 0);
        // R10 register link to rd
        step(4'd12, 0, 0, 0, 0, 32'h0040_1000, 5'd5, 1, 0);
        // R11 exception cancels a linked jump
        step(4'd10, 0, 0, 0, 26'h123, 0, 0, 1, 1);
        // R12 no retire
        step(4'd11, 0, 0, 0, 0, 32'hDEAD_BEEF, 0, 0, 0);
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = ($urandom % 5 == 0) ? 32'h0 : $urandom;
            step(4'($urandom % 16), a, ($urandom % 3 == 0) ? a : $urandom,
                 16'($urandom), 26'($urandom), $urandom, 5'($urandom),
                 ($urandom % 5) != 0, ($urandom % 10) == 0);
        end
        do_reset();
        step(4'd0, 0, 0, 0, 0, 0, 0, 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule